// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one machine-cycle request from an 8-bit processor core into pin-level bus timing on a bus that shares its low byte between address and data. A separate high byte carries the upper address bits. Each cycle opens with an address state, in which the low address byte is on the shared lines and an address strobe pulses. One or more transfer states follow, in which the same lines carry data under an active-low read, write or interrupt-acknowledge strobe. A three-bit status word names the cycle type for the whole cycle. A slow device can stretch a cycle by holding the ready input low, and another bus master can take the bus between cycles through a hold request and grant pair.

The core side is a valid/ready request stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The core must hold its request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only when the sequencer is between cycles, owns the bus and sees no hold request. The response side has no back-pressure: `rsp_valid` is a one-clock pulse that the core must take when it occurs. `rsp_rdata` stays valid until the next read-type cycle completes. When the core has nothing to issue, it can raise `core_halt` to park the sequencer in a halted state with the bus floated.

Top module: `bus_seq`

## Requirements
- R1: While `rst_n` is low, `bus_oe` is 0. In the first clock after reset the address strobe is 0, all three strobes are 1, `hold_gnt` is 0, `rsp_valid` is 0, and `bus_idle` and `req_ready` are 1.
- R2: The address strobe is high for exactly one clock, the first clock after acceptance (T1), and only for cycles that are not bus-idle. In T1, `mux_o` equals the low address byte, `mux_oe` is 1 and `addr_hi` equals the high address byte.
- R3: `cyc_stat` = {io space, S1, S0} is set from T1 to the last state of the cycle and is 000 between cycles. The codes are: memory read 010, memory write 001, I/O read 110, I/O write 101, opcode fetch 011, interrupt acknowledge 111, bus idle 000. `req_type` codes are: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 opcode fetch, 5 interrupt acknowledge, 6 and 7 bus idle.
- R4: In I/O cycles, `addr_hi` carries the port number, which is the low address byte, so the low byte appears on both halves.
- R5: In memory read, I/O read and fetch cycles, `rd_strobe_n` is low from T2 through T3, including any wait states, and `mux_oe` is 0 during that time. `mux_i` is captured on the last clock of T3, and `rsp_valid` pulses on the next clock with that byte on `rsp_rdata`. Between cycles all strobes are high.
- R6: In write cycles, `wr_strobe_n` is low from T2 through T3, and `mux_o` carries the write byte with `mux_oe` high for as long as `wr_strobe_n` is low.
- R7: `xfer_ready` is sampled at the end of T2 and of each wait state. Each sample found low adds one whole-clock wait state before T3.
- R8: An opcode fetch adds FETCH_EXTRA states after T3 (default 1) with no strobe and the status still driven. `rsp_valid` still follows T3, and the next request is accepted only after those states.
- R9: In an interrupt-acknowledge cycle, `ack_strobe_n` takes the place of `rd_strobe_n` with the same timing, and the read strobe stays high. At most one strobe is ever low.
- R10: A bus-idle cycle lasts exactly three clocks. It has no address strobe, no strobe, and `mux_oe` 0, and it ignores `xfer_ready`.
- R11: `hold_req` is acted on only between cycles. A cycle in progress completes, and `hold_gnt` rises one clock after the sequencer is back between cycles. While granted, `bus_oe` is 0 and `req_ready` is 0. After `hold_req` falls, `hold_gnt` drops and `bus_oe` returns on the next clock.
- R12: When `core_halt` is high between cycles with no request and no hold, the sequencer enters the halted state on the next clock. There `halted` is 1, `bus_oe` is 0 and `req_ready` is 0, until `core_halt` falls.
- R13: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. Hold has priority over a request, and a request has priority over halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request can be accepted this clock |
| req_type | input | 3 | Cycle type code |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-clock pulse after T3 |
| rsp_rdata | output | DATA_W | Captured read byte |
| core_halt | input | 1 | Core requests halted state |
| addr_strobe | output | 1 | Address latch strobe, never floated |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| ack_strobe_n | output | 1 | Active-low interrupt acknowledge strobe |
| cyc_stat | output | 3 | Cycle status {io space, S1, S0} |
| addr_hi | output | ADDR_W-DATA_W | High address byte |
| mux_o | output | DATA_W | Shared address/data lines, out |
| mux_i | input | DATA_W | Shared address/data lines, in |
| mux_oe | output | 1 | Drive enable for shared lines |
| bus_oe | output | 1 | Drive enable for high address, strobes and status |
| xfer_ready | input | 1 | Device ready; low inserts wait states |
| hold_req | input | 1 | Other master requests the bus |
| hold_gnt | output | 1 | Bus granted to other master |
| halted | output | 1 | Sequencer parked in halted state |
| bus_idle | output | 1 | Between cycles, bus owned |

## Verification
Acceptance happens on the edge where valid and ready meet. T1 is visible in the next clock, the strobes fall one clock later, each low ready sample adds one clock, and `rsp_valid` shows in the clock after T3. `hold_gnt` and `halted` appear one clock after the between-cycles state in which their input is seen. The bench drives inputs and samples outputs on the falling edge. It counts clocks from acceptance and compares every output against a per-clock expectation, so a strobe that is one clock early or late shows up as a mismatch at that clock.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CT_MEM_RD = 3'd0,
    CT_MEM_WR = 3'd1,
    CT_IO_RD  = 3'd2,
    CT_IO_WR  = 3'd3,
    CT_FETCH  = 3'd4,
    CT_INTA   = 3'd5,
    CT_IDLE   = 3'd6,
    CT_SPARE  = 3'd7
  } cyc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_HALT, ST_HOLD
  } state_t;

  // {io space, S1, S0}
  function automatic logic [2:0] status_code(input cyc_t t);
    case (t)
      CT_MEM_RD: status_code = 3'b010;
      CT_MEM_WR: status_code = 3'b001;
      CT_IO_RD:  status_code = 3'b110;
      CT_IO_WR:  status_code = 3'b101;
      CT_FETCH:  status_code = 3'b011;
      CT_INTA:   status_code = 3'b111;
      default:   status_code = 3'b000;
    endcase
  endfunction

  function automatic logic is_dead(input cyc_t t);
    is_dead = (t == CT_IDLE) || (t == CT_SPARE);
  endfunction

  function automatic logic is_read(input cyc_t t);
    is_read = (t == CT_MEM_RD) || (t == CT_IO_RD) || (t == CT_FETCH);
  endfunction

  function automatic logic is_write(input cyc_t t);
    is_write = (t == CT_MEM_WR) || (t == CT_IO_WR);
  endfunction

  function automatic logic is_io(input cyc_t t);
    is_io = (t == CT_IO_RD) || (t == CT_IO_WR);
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
`timescale 1ns/1ps
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int FETCH_EXTRA = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              xfer_ready,
  input  logic              hold_req,
  input  logic              core_halt,
  output logic              req_ready,
  output state_t            state,
  output cyc_t              cyc,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  localparam int CW = (FETCH_EXTRA > 1) ? $clog2(FETCH_EXTRA) : 1;

  state_t        nxt;
  logic [CW-1:0] cnt, cnt_d;
  logic          take;

  assign req_ready = (state == ST_IDLE) && !hold_req;

  always_comb begin
    nxt   = state;
    cnt_d = cnt;
    take  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hold_req)       nxt = ST_HOLD;
        else if (req_valid) begin nxt = ST_T1; take = 1'b1; end
        else if (core_halt) nxt = ST_HALT;
      end
      ST_T1: nxt = ST_T2;
      ST_T2, ST_TW: begin
        if (is_dead(cyc) || xfer_ready) nxt = ST_T3;
        else                            nxt = ST_TW;
      end
      ST_T3: begin
        if ((cyc == CT_FETCH) && (FETCH_EXTRA > 0)) begin
          nxt   = ST_T4;
          cnt_d = CW'(FETCH_EXTRA - 1);
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_T4: begin
        if (cnt == '0) nxt = ST_IDLE;
        else           cnt_d = cnt - 1'b1;
      end
      ST_HALT: begin
        if (hold_req)        nxt = ST_HOLD;
        else if (!core_halt) nxt = ST_IDLE;
      end
      ST_HOLD: if (!hold_req) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cyc     <= CT_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_d;
      if (take) begin
        cyc     <= cyc_t'(req_type);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/bus_seq_drive.sv
`timescale 1ns/1ps
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     rst_n,
  input  state_t                   state,
  input  cyc_t                     cyc,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic                     addr_strobe,
  output logic                     rd_strobe_n,
  output logic                     wr_strobe_n,
  output logic                     ack_strobe_n,
  output logic [2:0]               cyc_stat,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        mux_o,
  output logic                     mux_oe,
  output logic                     bus_oe,
  output logic                     hold_gnt,
  output logic                     halted,
  output logic                     bus_idle
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic in_cycle, strobe, dead;

  assign dead     = is_dead(cyc);
  assign in_cycle = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) ||
                    (state == ST_T3) || (state == ST_T4);
  assign strobe   = !dead && ((state == ST_T2) || (state == ST_TW) || (state == ST_T3));

  always_comb begin
    addr_strobe  = (state == ST_T1) && !dead;
    rd_strobe_n  = !(strobe && is_read(cyc));
    wr_strobe_n  = !(strobe && is_write(cyc));
    ack_strobe_n = !(strobe && (cyc == CT_INTA));
    cyc_stat     = in_cycle ? status_code(cyc) : 3'b000;
    addr_hi      = is_io(cyc) ? HI_W'(addr_q[DATA_W-1:0]) : addr_q[ADDR_W-1:DATA_W];
    mux_o        = (state == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
    bus_oe       = rst_n && (state != ST_HALT) && (state != ST_HOLD);
    mux_oe       = bus_oe && !dead &&
                   ((state == ST_T1) || (strobe && is_write(cyc)));
    hold_gnt     = (state == ST_HOLD);
    halted       = (state == ST_HALT);
    bus_idle     = (state == ST_IDLE);
  end

endmodule

// File: rtl/bus_seq_capture.sv
`timescale 1ns/1ps
module bus_seq_capture
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state,
  input  cyc_t              cyc,
  input  logic [DATA_W-1:0] mux_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic grab;
  assign grab = (state == ST_T3) && (is_read(cyc) || (cyc == CT_INTA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (state == ST_T3);
      if (grab) rsp_rdata <= mux_i;
    end
  end

endmodule

// File: rtl/bus_seq.sv
`timescale 1ns/1ps
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int FETCH_EXTRA = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_type,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic                     core_halt,
  output logic                     addr_strobe,
  output logic                     rd_strobe_n,
  output logic                     wr_strobe_n,
  output logic                     ack_strobe_n,
  output logic [2:0]               cyc_stat,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        mux_o,
  input  logic [DATA_W-1:0]        mux_i,
  output logic                     mux_oe,
  output logic                     bus_oe,
  input  logic                     xfer_ready,
  input  logic                     hold_req,
  output logic                     hold_gnt,
  output logic                     halted,
  output logic                     bus_idle
);

  state_t            state;
  cyc_t              cyc;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FETCH_EXTRA(FETCH_EXTRA)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .xfer_ready(xfer_ready),
    .hold_req(hold_req), .core_halt(core_halt), .req_ready(req_ready),
    .state(state), .cyc(cyc), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .rst_n(rst_n), .state(state), .cyc(cyc), .addr_q(addr_q), .wdata_q(wdata_q),
    .addr_strobe(addr_strobe), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .ack_strobe_n(ack_strobe_n), .cyc_stat(cyc_stat), .addr_hi(addr_hi),
    .mux_o(mux_o), .mux_oe(mux_oe), .bus_oe(bus_oe), .hold_gnt(hold_gnt),
    .halted(halted), .bus_idle(bus_idle)
  );

  bus_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .state(state), .cyc(cyc), .mux_i(mux_i),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/bus_seq_chk.sv
`timescale 1ns/1ps
module bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       addr_strobe,
  input logic       rd_strobe_n,
  input logic       wr_strobe_n,
  input logic       ack_strobe_n,
  input logic [2:0] cyc_stat,
  input logic       mux_oe,
  input logic       bus_oe,
  input logic       hold_gnt,
  input logic       halted,
  input logic       bus_idle
);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe); // R2

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n || !ack_strobe_n) |-> $stable(cyc_stat)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> mux_oe); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rd_strobe_n, !wr_strobe_n, !ack_strobe_n})); // R9

  AST_GNT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_gnt |-> (!bus_oe && !req_ready)); // R11

  AST_HALT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!bus_oe && !req_ready)); // R12

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_idle && bus_oe)); // R13

endmodule

bind bus_seq bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .addr_strobe(addr_strobe), .rd_strobe_n(rd_strobe_n),
  .wr_strobe_n(wr_strobe_n), .ack_strobe_n(ack_strobe_n), .cyc_stat(cyc_stat),
  .mux_oe(mux_oe), .bus_oe(bus_oe), .hold_gnt(hold_gnt), .halted(halted),
  .bus_idle(bus_idle)
);

// File: tb/bus_seq_bench.sv
`timescale 1ns/1ps
module bus_seq_bench;

  localparam int FE = 1;
  localparam int NV = 10;
  // {type[3], addr[16], wdata[8], rdata[8], waits[4]}
  localparam logic [38:0] VEC [NV] = '{
    {3'd0, 16'h12A5, 8'h00, 8'h3C, 4'd0},
    {3'd1, 16'h8001, 8'h5A, 8'h00, 4'd0},
    {3'd2, 16'h0077, 8'h00, 8'hC3, 4'd0},
    {3'd3, 16'hFF42, 8'h99, 8'h00, 4'd1},
    {3'd4, 16'h4000, 8'h00, 8'h0E, 4'd0},
    {3'd5, 16'h0000, 8'h00, 8'hFF, 4'd0},
    {3'd6, 16'h3333, 8'h00, 8'h00, 4'd2},
    {3'd0, 16'hBEEF, 8'h00, 8'hA1, 4'd3},
    {3'd1, 16'h0100, 8'h00, 8'h00, 4'd2},
    {3'd4, 16'h0010, 8'h00, 8'hC9, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, core_halt = 1'b0, xfer_ready = 1'b1, hold_req = 1'b0;
  logic [2:0] req_type = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, mux_i = '0;
  logic req_ready, rsp_valid, addr_strobe, rd_strobe_n, wr_strobe_n, ack_strobe_n;
  logic mux_oe, bus_oe, hold_gnt, halted, bus_idle;
  logic [2:0] cyc_stat;
  logic [7:0] addr_hi, mux_o, rsp_rdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bus_seq #(.FETCH_EXTRA(FE)) u_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_halt(core_halt),
    .addr_strobe(addr_strobe), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .ack_strobe_n(ack_strobe_n), .cyc_stat(cyc_stat), .addr_hi(addr_hi),
    .mux_o(mux_o), .mux_i(mux_i), .mux_oe(mux_oe), .bus_oe(bus_oe),
    .xfer_ready(xfer_ready), .hold_req(hold_req), .hold_gnt(hold_gnt),
    .halted(halted), .bus_idle(bus_idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] enc(input logic [2:0] t);
    case (t)
      3'd0: enc = 3'b010;
      3'd1: enc = 3'b001;
      3'd2: enc = 3'b110;
      3'd3: enc = 3'b101;
      3'd4: enc = 3'b011;
      3'd5: enc = 3'b111;
      default: enc = 3'b000;
    endcase
  endfunction

  task automatic run_vec(input int i);
    logic [2:0] t = VEC[i][38:36];
    logic [15:0] a = VEC[i][35:20];
    logic [7:0] wd = VEC[i][19:12];
    logic [7:0] rd = VEC[i][11:4];
    int w = int'(VEC[i][3:0]);
    bit dead = (t >= 3'd6);
    bit rdt = (t == 3'd0) || (t == 3'd2) || (t == 3'd4);
    bit wrt = (t == 3'd1) || (t == 3'd3);
    bit io = (t == 3'd2) || (t == 3'd3);
    bit fet = (t == 3'd4);
    int eff = dead ? 0 : w;
    int last = 3 + eff;
    int kend = last + 1 + (fet ? FE : 0);
    string tg = dead ? "R10" : fet ? "R8" : (t == 3'd5) ? "R9" : wrt ? "R6" : "R5";
    string tgs = (eff > 0) ? "R7" : tg;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_wdata = wd;
    mux_i = rd; xfer_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    chk("R13 accept ready", {31'd0, req_ready}, 32'd1);
    for (int k = 1; k <= kend; k++) begin
      bit stb;
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      stb = !dead && (k >= 2) && (k <= last);
      chk("R2 address strobe", {31'd0, addr_strobe}, {31'd0, (k == 1) && !dead});
      chk({tgs, " strobes rd/wr/ack"}, {29'd0, rd_strobe_n, wr_strobe_n, ack_strobe_n},
          {29'd0, !(stb && rdt), !(stb && wrt), !(stb && (t == 3'd5))});
      chk("R3 status", {29'd0, cyc_stat},
          {29'd0, ((k <= last) || (fet && (k <= last + FE))) ? enc(t) : 3'b000});
      chk({tg, " mux_oe"}, {31'd0, mux_oe}, {31'd0, !dead && ((k == 1) || (stb && wrt))});
      chk({tg, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, k == last + 1});
      if (k == 1 && !dead) begin
        chk("R2 low address", {24'd0, mux_o}, {24'd0, a[7:0]});
        chk(io ? "R4 port on high byte" : "R2 high address", {24'd0, addr_hi},
            {24'd0, io ? a[7:0] : a[15:8]});
      end
      if (stb && wrt) chk("R6 write data", {24'd0, mux_o}, {24'd0, wd});
      if ((k == last + 1) && (rdt || t == 3'd5)) chk({tg, " read data"}, {24'd0, rsp_rdata}, {24'd0, rd});
      xfer_ready = !((k >= 2) && (k < 2 + w));
    end
    xfer_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 floated in reset", {31'd0, bus_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {28'd0, addr_strobe, rd_strobe_n, wr_strobe_n, ack_strobe_n}, 32'h7);
    chk("R1 grant/rsp after reset", {30'd0, hold_gnt, rsp_valid}, 32'd0);
    chk("R1 idle/ready after reset", {30'd0, bus_idle, req_ready}, 32'h3);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: hold raised mid-cycle waits for the boundary
    @(negedge clk);
    req_valid = 1'b1; req_type = 3'd0; req_addr = 16'h2222; mux_i = 8'h44;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0; hold_req = 1'b1;                  // T1
    @(negedge clk);
    chk("R11 transfer continues", {30'd0, rd_strobe_n, hold_gnt}, 32'd0); // T2
    @(negedge clk);
    chk("R11 T3 continues", {30'd0, rd_strobe_n, hold_gnt}, 32'd0);
    @(negedge clk);
    chk("R11 boundary no grant yet", {29'd0, rsp_valid, hold_gnt, req_ready}, 32'h4);
    @(negedge clk);
    chk("R11 granted and floated", {29'd0, hold_gnt, bus_oe, addr_strobe}, 32'h4);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R13 held request not taken", {30'd0, req_ready, hold_gnt}, 32'h1);
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk("R11 released", {29'd0, hold_gnt, bus_oe, req_ready}, 32'h3);

    // R12: halt while idle
    core_halt = 1'b1;
    @(negedge clk);
    chk("R12 halted floats", {28'd0, halted, bus_oe, req_ready, bus_idle}, 32'h8);
    core_halt = 1'b0;
    @(negedge clk);
    chk("R12 halt released", {29'd0, halted, bus_oe, bus_idle}, 32'h3);

    // R13: request wins over halt
    req_valid = 1'b1; core_halt = 1'b1; req_type = 3'd1; req_addr = 16'h0F0F;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 request before halt", {30'd0, addr_strobe, halted}, 32'h2);
    core_halt = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 back between cycles", {30'd0, halted, bus_idle}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule